// File: doc/BRIEF.md
# Dual-Bank Flash Program Command Interface

This block models the write and command side of a parallel NOR flash built from two independent banks. All bus inputs are sampled by a system clock. A write cycle exists only while both the active-low chip-enable and write-enable inputs are low. The address is taken when that combined strobe becomes active, and the data when it becomes inactive. A program operation is started by three fixed unlock writes followed by a fourth write that carries the target address and data.

Once the fourth write completes, the addressed bank goes busy for a fixed number of clock cycles. During that time, reads of that bank return a status byte instead of array data. Reads of the other bank keep returning array data. Commands written while a bank is busy are dropped.

The storage is a register array that reset fills with ones. A program write can only clear bits. A byte-mode input selects whether a program touches one byte lane or the whole word, and whether reads return a zero-extended byte or the full word.

Top module: `dual_bank_flash_ctl`

## Requirements
- R1: A write cycle is recognised only while ce_n and we_n are both low; holding we_n low while ce_n is high has no effect on the command state, on busy or on the array.
- R2: The address of a write cycle is the value on addr in the first clock where ce_n and we_n are both low; later changes during the strobe are ignored.
- R3: The data of a write cycle is the value on din in the first clock after the strobe ends; values present earlier in the strobe are ignored.
- R4: A program needs these three writes in order, with word index addr[8:1] and key din[7:0]: (0x55, 0xAA), (0x2A, 0x55), (0x55, 0xA0). The fourth write then programs its address and data.
- R5: The busy bit of the target bank (busy[0] for word index bit 7 = 0, busy[1] otherwise) is high for exactly PROG_CYCLES clocks, starting in the clock after the fourth write ends.
- R6: Writes made while any busy bit is high are ignored, and at most one busy bit is high at a time.
- R7: A read of a busy bank returns a status word: bit 7 is the complement of din[7] of the programmed data, bit 6 is 1 on the first read after the program starts and inverts on every later read, and all other bits are 0.
- R8: A read of the idle bank returns array data while the other bank is busy.
- R9: With byte_mode high, a program changes only the byte lane picked by addr[0] (1 = upper byte). A read returns the selected byte in dout[7:0] with dout[15:8] = 0.
- R10: Any unlock write whose index or key does not match returns the decoder to idle, so no program follows.
- R11: A program stores the old word ANDed with the new data.
- R12: After reset, busy is 0, dout is 0 and every array word reads 0xFFFF.
- R13: Once busy falls, a read of the programmed location returns the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable, a read needs ce_n low, oe_n low and we_n high |
| byte_mode | input | 1 | High selects byte-wide programming and reads |
| addr | input | 9 | Word index in bits 8:1, byte lane in bit 0 |
| din | input | 16 | Write data bus |
| dout | output | 16 | Registered read data, 0 when no read is active |
| busy | output | 2 | Per-bank program-in-progress flags |

## Verification
Three things can coincide: a program running in one bank, a read of the other bank, and a fresh command sequence arriving on the write strobe. The bench starts a program in bank 0 and, inside its busy window, reads bank 0 (status and toggle), reads bank 1 (array data), and writes a complete unlock and program sequence aimed at bank 1. It then judges that busy[1] never rose, that the bank-1 data came back unchanged, that the dropped target still reads all ones, and that bank 0 finished with the expected AND result.

// File: rtl/flash_cmd_pkg.sv
// Shared definitions for the dual-bank flash command interface.
// Assumes exactly two banks selected by the top bit of the word index.
package flash_cmd_pkg;
    localparam int NUM_BANKS = 2;

    // Progress of the software-protected program sequence
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2,
        SEQ_ARMED  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/fcmd_strobe_sampler.sv
// Turns sampled ce_n/we_n/oe_n into write-cycle and read events.
// Latches the address when the combined write strobe turns active and
// flags completion when it turns inactive. Assumes synchronous bus inputs.
module fcmd_strobe_sampler #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    output logic          wr_done,
    output logic [AW-1:0] wr_addr,
    output logic          rd_act,
    output logic          rd_start
);
    logic wr_act, wr_act_q, rd_act_q;

    assign wr_act   = ~ce_n & ~we_n;
    assign rd_act   = ~ce_n & ~oe_n & we_n;
    assign wr_done  = wr_act_q & ~wr_act;
    assign rd_start = rd_act & ~rd_act_q;

    // Remember last strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
        end
    end

    // Capture the address at the start of the write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_addr <= '0;
        else if (wr_act && !wr_act_q)
            wr_addr <= addr;
    end

    assert_write_needs_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(!ce_n && !we_n));
endmodule

// File: rtl/fcmd_unlock_decoder.sv
// Tracks the three unlock writes and fires prog_go on the fourth write.
// Writes that arrive while the engine is busy leave the state untouched.
module fcmd_unlock_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          IDX_W = 8,
    parameter int          KEY_W = 8,
    parameter logic [IDX_W-1:0] IDX_A = 8'h55,
    parameter logic [IDX_W-1:0] IDX_B = 8'h2A,
    parameter logic [KEY_W-1:0] KEY_1 = 8'hAA,
    parameter logic [KEY_W-1:0] KEY_2 = 8'h55,
    parameter logic [KEY_W-1:0] KEY_3 = 8'hA0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_done,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             engine_busy,
    output logic             prog_go
);
    seq_state_t state, state_nxt;
    logic accept;

    assign accept  = wr_done & ~engine_busy;
    assign prog_go = accept & (state == SEQ_ARMED);

    // Next-state choice for an accepted write
    always_comb begin
        state_nxt = state;
        if (accept) begin
            unique case (state)
                SEQ_IDLE:   state_nxt = (wr_idx == IDX_A && wr_key == KEY_1) ? SEQ_FIRST  : SEQ_IDLE;
                SEQ_FIRST:  state_nxt = (wr_idx == IDX_B && wr_key == KEY_2) ? SEQ_SECOND : SEQ_IDLE;
                SEQ_SECOND: state_nxt = (wr_idx == IDX_A && wr_key == KEY_3) ? SEQ_ARMED  : SEQ_IDLE;
                default:    state_nxt = SEQ_IDLE;
            endcase
        end
    end

    // Sequence state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nxt;
    end

    assert_busy_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && engine_busy) |=> (state == $past(state)));
endmodule

// File: rtl/fcmd_prog_timer.sv
// Per-bank program timer and status source. Holds busy for PROG_CYCLES
// clocks after start, keeps the data MSB for status and the read toggle.
module fcmd_prog_timer #(
    parameter int PROG_CYCLES = 1750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic data_msb,
    input  logic rd_start_here,
    output logic busy,
    output logic status_msb,
    output logic toggle_nxt
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    logic [CW-1:0] cnt;
    logic          toggle;

    assign toggle_nxt = toggle ^ (rd_start_here & busy);

    // Countdown of the fixed program time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(PROG_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Status bits: inverted data MSB and per-read toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_msb <= 1'b0;
            toggle     <= 1'b0;
        end else if (start) begin
            status_msb <= ~data_msb;
            toggle     <= 1'b0;
        end else begin
            toggle     <= toggle_nxt;
        end
    end

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && cnt == CW'(PROG_CYCLES - 1)));
endmodule

// File: rtl/fcmd_bank_array.sv
// One bank of storage, reset to all ones. A write clears bits only:
// the stored word becomes old AND new. Asynchronous read port.
module fcmd_bank_array #(
    parameter int ROW_W = 7,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [DW-1:0]    wr_data,
    input  logic [ROW_W-1:0] rd_row,
    output logic [DW-1:0]    rd_word
);
    localparam int ROWS = 1 << ROW_W;
    logic [DW-1:0] mem [ROWS];

    assign rd_word = mem[rd_row];

    // Erase on reset, AND-in program data otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_row] <= mem[wr_row] & wr_data;
        end
    end
endmodule

// File: rtl/dual_bank_flash_ctl.sv
// Top of the dual-bank flash command interface. Samples the parallel bus,
// decodes the unlock + program sequence, runs one program at a time and
// serves reads: status for the busy bank, array data for the other.
// Assumes DATA_W is two bytes and addr bit 0 is the byte lane.
module dual_bank_flash_ctl
    import flash_cmd_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 1750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              byte_mode,
    input  logic [IDX_W:0]    addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [NUM_BANKS-1:0] busy
);
    localparam int BYTE_W = DATA_W / 2;
    localparam int ROW_W  = IDX_W - 1;

    logic             wr_done, rd_act, rd_start, prog_go, busy_any;
    logic [IDX_W:0]   wr_addr;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             wr_bank, rd_bank;
    logic [DATA_W-1:0] wr_mask, rd_sel, rd_val, status;
    logic [DATA_W-1:0] bank_word [NUM_BANKS];
    logic [NUM_BANKS-1:0] stat_msb, tog_nxt;

    assign wr_idx   = wr_addr[IDX_W:1];
    assign wr_bank  = wr_idx[IDX_W-1];
    assign rd_idx   = addr[IDX_W:1];
    assign rd_bank  = rd_idx[IDX_W-1];
    assign busy_any = |busy;

    fcmd_strobe_sampler #(.AW(IDX_W + 1)) u_smp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wr_done(wr_done), .wr_addr(wr_addr),
        .rd_act(rd_act), .rd_start(rd_start)
    );

    fcmd_unlock_decoder #(.IDX_W(IDX_W), .KEY_W(BYTE_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .wr_idx(wr_idx),
        .wr_key(din[BYTE_W-1:0]), .engine_busy(busy_any), .prog_go(prog_go)
    );

    // Program data as an AND mask: untouched byte lane stays all ones
    always_comb begin
        if (!byte_mode)
            wr_mask = din;
        else if (wr_addr[0])
            wr_mask = {din[BYTE_W-1:0], {BYTE_W{1'b1}}};
        else
            wr_mask = {{BYTE_W{1'b1}}, din[BYTE_W-1:0]};
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        fcmd_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
            .clk(clk), .rst_n(rst_n),
            .start(prog_go && (wr_bank == 1'(b))),
            .data_msb(din[BYTE_W-1]),
            .rd_start_here(rd_start && (rd_bank == 1'(b))),
            .busy(busy[b]), .status_msb(stat_msb[b]), .toggle_nxt(tog_nxt[b])
        );
        fcmd_bank_array #(.ROW_W(ROW_W), .DW(DATA_W)) u_arr (
            .clk(clk), .rst_n(rst_n),
            .wr_en(prog_go && (wr_bank == 1'(b))),
            .wr_row(wr_idx[ROW_W-1:0]), .wr_data(wr_mask),
            .rd_row(rd_idx[ROW_W-1:0]), .rd_word(bank_word[b])
        );
    end

    // Select array word or byte, and build the status word
    always_comb begin
        rd_sel = bank_word[rd_bank];
        if (byte_mode)
            rd_val = {{BYTE_W{1'b0}}, addr[0] ? rd_sel[DATA_W-1:BYTE_W] : rd_sel[BYTE_W-1:0]};
        else
            rd_val = rd_sel;
        status = '0;
        status[BYTE_W-1] = stat_msb[rd_bank];
        status[BYTE_W-2] = tog_nxt[rd_bank];
    end

    // Registered read output
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (!rd_act) dout <= '0;
        else              dout <= busy[rd_bank] ? status : rd_val;
    end

    assert_single_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy));
    assert_go_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> busy_any);
    assert_status_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && busy[rd_bank]) |=>
            (dout[DATA_W-1:BYTE_W] == '0 && dout[BYTE_W-3:0] == '0));
endmodule

// File: tb/sim_dual_bank_flash_ctl.sv
module sim_dual_bank_flash_ctl;
    localparam int P = 64;
    localparam logic [8:0] UA = 9'h0AA;
    localparam logic [8:0] UB = 9'h054;

    logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_mode = 1'b0;
    logic [8:0]  addr = '0;
    logic [15:0] din = '0, dout, v;
    logic [1:0]  busy;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    dual_bank_flash_ctl #(.IDX_W(8), .DATA_W(16), .PROG_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_mode(byte_mode), .addr(addr), .din(din), .dout(dout), .busy(busy)
    );

    // op 0 = program (addr,data), op 1 = read (addr, expected)
    localparam logic [42:0] VEC [8] = '{
        {2'd0, 9'h020, 16'h1234, 16'h0000},
        {2'd1, 9'h020, 16'h0000, 16'h1234},
        {2'd0, 9'h020, 16'hFF0F, 16'h0000},
        {2'd1, 9'h020, 16'h0000, 16'h1204},
        {2'd0, 9'h120, 16'hA5C3, 16'h0000},
        {2'd1, 9'h120, 16'h0000, 16'hA5C3},
        {2'd1, 9'h030, 16'h0000, 16'hFFFF},
        {2'd1, 9'h1FE, 16'h0000, 16'hFFFF}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Write cycle: wrong data early, wrong address late (R2, R3)
    task automatic wr(input logic [8:0] a, input logic [15:0] d, input logic ce_low);
        @(negedge clk); addr = a; din = d ^ 16'h5A5A; ce_n = ~ce_low; we_n = 1'b0;
        @(negedge clk); addr = a ^ 9'h1FF; din = d;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic prog(input logic [8:0] a, input logic [15:0] d);
        wr(UA, 16'h00AA, 1'b1); wr(UB, 16'h0055, 1'b1);
        wr(UA, 16'h00A0, 1'b1); wr(a, d, 1'b1);
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] r);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); r = dout; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy != 2'b00) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 dout", dout, 16'h0000);
        check("R12 busy", {14'h0, busy}, 16'h0000);
        rd(9'h042, v); check("R12 erased", v, 16'hFFFF);

        // Table walk, word mode (R4, R11, R13)
        foreach (VEC[i]) begin
            if (VEC[i][42:41] == 2'd0) begin
                prog(VEC[i][40:32], VEC[i][31:16]);
                wait_idle();
            end else begin
                rd(VEC[i][40:32], v);
                check("R4 R11 R13 vector", v, VEC[i][15:0]);
            end
        end

        // R1: full sequence with ce_n high does nothing
        wr(UA, 16'h00AA, 1'b0); wr(UB, 16'h0055, 1'b0);
        wr(UA, 16'h00A0, 1'b0); wr(9'h060, 16'h0000, 1'b0);
        @(negedge clk); check("R1 busy", {14'h0, busy}, 16'h0000);
        rd(9'h060, v); check("R1 array", v, 16'hFFFF);

        // R10: wrong key, then wrong index
        wr(UA, 16'h00AA, 1'b1); wr(UB, 16'h0055, 1'b1);
        wr(UA, 16'h0080, 1'b1); wr(9'h060, 16'h0000, 1'b1);
        @(negedge clk); check("R10 key busy", {14'h0, busy}, 16'h0000);
        wr(UA, 16'h00AA, 1'b1); wr(9'h056, 16'h0055, 1'b1);
        wr(UA, 16'h00A0, 1'b1); wr(9'h060, 16'h0000, 1'b1);
        @(negedge clk); check("R10 idx busy", {14'h0, busy}, 16'h0000);
        rd(9'h060, v); check("R10 array", v, 16'hFFFF);

        // R5: busy duration
        begin
            int n = 0;
            prog(9'h044, 16'h7777);
            @(negedge clk);
            while (busy != 2'b00) begin
                if (busy != 2'b01) check("R5 bank", {14'h0, busy}, 16'h0001);
                n++;
                @(negedge clk);
            end
            check("R5 length", 16'(n), 16'(P));
        end

        // Concurrent: status, toggle, other bank, dropped command (R6 R7 R8)
        prog(9'h042, 16'h0080);
        rd(9'h042, v); check("R7 first status", v, 16'h0040);
        rd(9'h042, v); check("R7 second status", v, 16'h0000);
        rd(9'h120, v); check("R8 idle bank", v, 16'hA5C3);
        prog(9'h122, 16'h0000);
        @(negedge clk); check("R6 busy", {14'h0, busy}, 16'h0001);
        rd(9'h042, v); check("R7 third status", v, 16'h0040);
        wait_idle();
        rd(9'h122, v); check("R6 dropped", v, 16'hFFFF);
        rd(9'h042, v); check("R13 done", v, 16'h0080);

        // R9: byte mode
        byte_mode = 1'b1;
        prog(9'h081, 16'h003C);
        wait_idle();
        rd(9'h081, v); check("R9 upper byte", v, 16'h003C);
        rd(9'h080, v); check("R9 lower byte", v, 16'h00FF);
        byte_mode = 1'b0;
        rd(9'h080, v); check("R9 word", v, 16'h3CFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule